// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a synchronous master for an asynchronous 32K x 8 static RAM. A client hands it one access at a time on a valid/ready handshake: a 15-bit byte address, a direction bit and, for writes, an 8-bit data byte. The controller turns each request into a strobe sequence on the memory pins. It drives active-low chip-select, output-enable and write-enable, holds the address on the memory pins, and drives or releases a shared bidirectional data bus. When the access ends it raises a one-cycle completion pulse, together with the read byte or an error flag.

The timing windows are fixed at elaboration as clock counts. These are the read access window, the write strobe width and the post-write recovery gap. A count of zero is treated as one. The address is presented one clock before any strobe falls and is not changed while the memory is selected. A single count covers all three read access limits, because chip-select and output-enable always fall in the same clock as each other and one clock after the address settles. A write-protect input guards the memory. A request that arrives while it is high is retired without touching the pins. A write already under way when it rises is cut short.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, `req_ready` is 1, all three strobes are 1 and `rsp_done` is 0.
- R2: A read holds `sram_ce_n` and `sram_oe_n` low together with `sram_we_n` high for exactly T_ACC cycles. The byte on `sram_dq` at the end of that window appears on `rsp_rdata`, with `rsp_done` high and `rsp_err` low, in the cycle after the (T_ACC+1)-th rising edge that follows the accepting edge.
- R3: A write holds `sram_ce_n` and `sram_we_n` low for exactly T_WP cycles while `sram_oe_n` stays high. `rsp_done` is high with `rsp_err` low in the cycle after the (T_WP+1)-th rising edge that follows the accepting edge.
- R4: `sram_addr` carries the request address in the cycle before `sram_ce_n` falls and stays unchanged while `sram_ce_n` is low.
- R5: The controller drives `sram_dq` only while `sram_we_n` is low and for one cycle after it rises, and in that extra cycle the bus still carries the write byte.
- R6: After `sram_we_n` rises, `sram_ce_n` stays high for at least T_REC+1 cycles, and `req_ready` is 0 whenever `sram_ce_n` is low.
- R7: A request accepted while `wr_protect` is 1 drives no strobe. It gives `rsp_done` and `rsp_err` high in the cycle after the accepting edge, and memory contents are unchanged.
- R8: If `wr_protect` is 1 at a rising edge while `sram_we_n` is low, then `sram_we_n` and `sram_ce_n` are high after that edge, and `rsp_done` and `rsp_err` are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| wr_protect | input | 1 | Refuse new accesses, cut active writes |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was refused or aborted |
| rsp_rdata | output | DATA_W | Last byte read |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq | inout | DATA_W | Bidirectional memory data bus |

## Verification
Counting rising edges from the one that accepts a request, a refused request completes after that same edge. A read completes after T_ACC+1 edges and a write after T_WP+1. A write cut short by protect completes one edge after protect is seen. The driver records the accepting edge number when it sees ready high with valid asserted. It then queues the due edge number along with the expected byte and error flag. The monitor samples on falling clock edges and compares each completion against the edge count at that moment. Strobe widths, address setup, bus hold and recovery gaps are measured the same way, in whole cycles between strobe transitions seen at falling edges.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_HOLD  = 3'd4,
        ST_RECOV = 3'd5
    } phase_e;

    // Timing counts below one are raised to one.
    function automatic logic [3:0] at_least_one(input logic [3:0] v);
        return (v == 4'd0) ? 4'd1 : v;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // High in the final cycle of a loaded window.
    assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/sram_strobe_reg.sv
`timescale 1ns/1ps
module sram_strobe_reg
    import sram_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_d,
    output logic   ce_n,
    output logic   oe_n,
    output logic   we_n,
    output logic   dq_en
);
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_en;
    } pins_t;

    pins_t pins_d, pins_q;

    // Strobes follow the next phase so they leave a flop, glitch free.
    always_comb begin
        pins_d.ce_n  = !((phase_d == ST_READ) || (phase_d == ST_WRITE));
        pins_d.oe_n  = !(phase_d == ST_READ);
        pins_d.we_n  = !(phase_d == ST_WRITE);
        pins_d.dq_en = (phase_d == ST_WRITE) || (phase_d == ST_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_en: 1'b0};
        else        pins_q <= pins_d;
    end

    assign ce_n  = pins_q.ce_n;
    assign oe_n  = pins_q.oe_n;
    assign we_n  = pins_q.we_n;
    assign dq_en = pins_q.dq_en;
endmodule

// File: rtl/sram_dq_port.sv
`timescale 1ns/1ps
module sram_dq_port #(
    parameter int DATA_W = 8
) (
    input  logic              drive_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] bus_in,
    inout  wire  [DATA_W-1:0] dq
);
    assign dq     = drive_en ? wdata : {DATA_W{1'bz}};
    assign bus_in = dq;
endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int         ADDR_W = 15,
    parameter int         DATA_W = 8,
    parameter logic [3:0] T_ACC  = 4'd3,
    parameter logic [3:0] T_WP   = 4'd2,
    parameter logic [3:0] T_REC  = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wr_protect,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    inout  wire  [DATA_W-1:0] sram_dq
);
    localparam int         CNT_W   = 4;
    localparam logic [3:0] ACC_CNT = at_least_one(T_ACC);
    localparam logic [3:0] WP_CNT  = at_least_one(T_WP);
    localparam logic [3:0] REC_CNT = at_least_one(T_REC);

    typedef struct packed {
        phase_e            phase;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              err;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              dq_en;
    logic [DATA_W-1:0] bus_in;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        ctrl_d.err  = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = ACC_CNT;
        unique case (ctrl_q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    if (wr_protect) begin
                        // Refused: retire without any strobe.
                        ctrl_d.done = 1'b1;
                        ctrl_d.err  = 1'b1;
                    end else begin
                        ctrl_d.addr  = req_addr;
                        ctrl_d.wdata = req_wdata;
                        ctrl_d.is_wr = req_write;
                        ctrl_d.phase = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                // Address has been stable for one cycle; open the strobes.
                tmr_load = 1'b1;
                if (ctrl_q.is_wr) begin
                    tmr_val      = WP_CNT;
                    ctrl_d.phase = ST_WRITE;
                end else begin
                    tmr_val      = ACC_CNT;
                    ctrl_d.phase = ST_READ;
                end
            end
            ST_READ: begin
                if (tmr_last) begin
                    ctrl_d.rdata = bus_in;
                    ctrl_d.done  = 1'b1;
                    ctrl_d.phase = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (wr_protect) begin
                    ctrl_d.done  = 1'b1;
                    ctrl_d.err   = 1'b1;
                    ctrl_d.phase = ST_HOLD;
                end else if (tmr_last) begin
                    ctrl_d.done  = 1'b1;
                    ctrl_d.phase = ST_HOLD;
                end
            end
            ST_HOLD: begin
                tmr_load     = 1'b1;
                tmr_val      = REC_CNT;
                ctrl_d.phase = ST_RECOV;
            end
            ST_RECOV: begin
                if (tmr_last) ctrl_d.phase = ST_IDLE;
            end
            default: ctrl_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_strobe_reg u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_d (ctrl_d.phase),
        .ce_n    (sram_ce_n),
        .oe_n    (sram_oe_n),
        .we_n    (sram_we_n),
        .dq_en   (dq_en)
    );

    sram_dq_port #(.DATA_W(DATA_W)) u_dq (
        .drive_en (dq_en),
        .wdata    (ctrl_q.wdata),
        .bus_in   (bus_in),
        .dq       (sram_dq)
    );

    assign req_ready = (ctrl_q.phase == ST_IDLE);
    assign rsp_done  = ctrl_q.done;
    assign rsp_err   = ctrl_q.err;
    assign rsp_rdata = ctrl_q.rdata;
    assign sram_addr = ctrl_q.addr;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              wr_protect,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              dq_en
);
    // R2
    read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    // R3
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n));

    // R4
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_ce_n) |-> $stable(sram_addr));

    // R4
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

    // R5
    bus_drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_en |-> (!sram_we_n || !$past(sram_we_n)));

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> !req_ready);

    // R7
    refuse_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && wr_protect) |=> (rsp_done && rsp_err && sram_ce_n));

    // R8
    protect_cuts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && wr_protect) |=> (sram_we_n && sram_ce_n && rsp_done && rsp_err));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .wr_protect (wr_protect),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_addr  (sram_addr),
    .dq_en      (dq_en)
);

// File: tb/sram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb;
    localparam int         ADDR_W = 15;
    localparam int         DATA_W = 8;
    localparam logic [3:0] T_ACC  = 4'd3;
    localparam logic [3:0] T_WP   = 4'd3;
    localparam logic [3:0] T_REC  = 4'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic wr_protect = 1'b0;
    logic req_ready, rsp_done, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] sram_addr;
    logic sram_ce_n, sram_oe_n, sram_we_n;
    wire  [DATA_W-1:0] sram_dq;

    always #2.5 clk = ~clk;

    sram_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ACC(T_ACC), .T_WP(T_WP), .T_REC(T_REC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .wr_protect(wr_protect), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq(sram_dq)
    );

    // ---------------- memory model ----------------
    logic [DATA_W-1:0] model_mem [logic [ADDR_W-1:0]];
    int                low_cnt = 0;
    logic [DATA_W-1:0] model_out;
    logic              model_drv;

    always @(posedge clk) begin
        if (!sram_ce_n && !sram_oe_n) low_cnt = low_cnt + 1;
        else                          low_cnt = 0;
        if (!sram_ce_n && !sram_we_n) model_mem[sram_addr] = sram_dq;
    end

    always @(*) begin
        if (low_cnt >= int'(T_ACC) - 1)
            model_out = model_mem.exists(sram_addr) ? model_mem[sram_addr] : 8'h00;
        else
            model_out = 8'hEE;
    end

    assign model_drv = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign sram_dq   = model_drv ? model_out : {DATA_W{1'bz}};

    // ---------------- bookkeeping ----------------
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit test_over = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    typedef struct {
        bit                wr;
        bit                err;
        logic [DATA_W-1:0] data;
        int                due;
    } exp_t;

    exp_t exp_q[$];
    logic [DATA_W-1:0] ref_mem [logic [ADDR_W-1:0]];
    int                exp_we_w = 0;
    logic [DATA_W-1:0] exp_wdata = '0;

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input bit prot, input bit abort);
        exp_t e;
        int   acc;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = a;
        req_wdata  = d;
        wr_protect = prot;
        if (wr) begin
            exp_wdata = d;
            exp_we_w  = abort ? 1 : int'(T_WP);
        end
        while (!req_ready) @(negedge clk);
        acc   = cyc + 1;
        e.wr  = wr;
        e.err = prot || abort;
        e.data = (!wr && ref_mem.exists(a)) ? ref_mem[a] : 8'h00;
        if (prot)       e.due = acc;
        else if (abort) e.due = acc + 2;
        else if (wr)    e.due = acc + int'(T_WP) + 1;
        else            e.due = acc + int'(T_ACC) + 1;
        exp_q.push_back(e);
        if (wr && !prot && !abort) ref_mem[a] = d;
        @(negedge clk);
        req_valid  = 1'b0;
        wr_protect = 1'b0;
        forever begin
            if (abort && cyc == acc + 1) wr_protect = 1'b1;
            if (rsp_done) break;
            @(negedge clk);
        end
        if (abort) begin
            // R8: strobes released in the completion cycle
            chk(sram_we_n && sram_ce_n, "R8 strobes high after cut", {sram_we_n, sram_ce_n}, 2'b11);
        end
        wr_protect = 1'b0;
        if (prot) begin
            // R7: no strobe in the completion cycle nor the next
            chk(sram_ce_n && sram_we_n && sram_oe_n, "R7 no strobe", sram_ce_n, 1);
            @(negedge clk);
            chk(sram_ce_n && sram_we_n && sram_oe_n, "R7 no strobe next", sram_ce_n, 1);
        end
    endtask

    // ---------------- monitor / scoreboard ----------------
    logic              prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;
    logic [ADDR_W-1:0] prev_addr = '0, win_addr = '0;
    int                we_run = 0, oe_run = 0, we_rise = 0;
    bit                rise_pending = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !test_over) begin
            if (rsp_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R3 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cyc == e.due, e.wr ? "R3 done timing" : "R2 done timing", cyc, e.due);
                    chk(rsp_err == e.err, e.err ? "R7/R8 error flag" : "R2/R3 error flag", rsp_err, e.err);
                    if (!e.wr && !e.err)
                        chk(rsp_rdata == e.data, "R2 read data", rsp_rdata, e.data);
                end
            end
            if (!sram_we_n) we_run++;
            if (!prev_we && sram_we_n) begin
                chk(we_run == exp_we_w, "R3 write strobe width", we_run, exp_we_w);
                chk(sram_dq == exp_wdata, "R5 bus hold byte", sram_dq, exp_wdata);
                we_run = 0;
                we_rise = cyc;
                rise_pending = 1'b1;
            end
            if (!sram_oe_n) oe_run++;
            if (!prev_oe && sram_oe_n) begin
                chk(oe_run == int'(T_ACC), "R2 read strobe width", oe_run, T_ACC);
                oe_run = 0;
            end
            if (!sram_we_n && !sram_oe_n) chk(1'b0, "R3 oe low during write", 0, 1);
            if (prev_ce && !sram_ce_n) begin
                chk(sram_addr == prev_addr, "R4 address setup", sram_addr, prev_addr);
                win_addr = sram_addr;
                if (rise_pending) begin
                    chk(cyc - we_rise >= int'(T_REC) + 1, "R6 recovery gap", cyc - we_rise, int'(T_REC) + 1);
                    rise_pending = 1'b0;
                end
            end
            if (!sram_ce_n) begin
                if (sram_addr != win_addr) chk(1'b0, "R4 address held", sram_addr, win_addr);
                if (req_ready) chk(1'b0, "R6 ready while selected", 1, 0);
            end
            prev_we   = sram_we_n;
            prev_oe   = sram_oe_n;
            prev_ce   = sram_ce_n;
            prev_addr = sram_addr;
        end
    end

    // ---------------- sequence ----------------
    task automatic report;
        if (!test_over) begin
            test_over = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(req_ready && sram_ce_n && sram_oe_n && sram_we_n && !rsp_done, "R1 reset state",
            {req_ready, sram_ce_n, sram_oe_n, sram_we_n, rsp_done}, 5'b11110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 after release
        chk(req_ready && sram_ce_n && sram_oe_n && sram_we_n && !rsp_done, "R1 idle after reset",
            {req_ready, sram_ce_n, sram_oe_n, sram_we_n, rsp_done}, 5'b11110);

        issue(1'b1, 15'h0001, 8'hA5, 1'b0, 1'b0);   // R3 R4 R5
        issue(1'b1, 15'h7FFF, 8'h3C, 1'b0, 1'b0);   // top address, R6 back-to-back
        issue(1'b0, 15'h0001, 8'h00, 1'b0, 1'b0);   // R2
        issue(1'b0, 15'h7FFF, 8'h00, 1'b0, 1'b0);   // R2
        issue(1'b0, 15'h1234, 8'h00, 1'b0, 1'b0);   // R2 unwritten byte
        issue(1'b1, 15'h1234, 8'h5A, 1'b0, 1'b0);
        issue(1'b1, 15'h1235, 8'hC3, 1'b0, 1'b0);   // R6 write after write
        issue(1'b0, 15'h1234, 8'h00, 1'b0, 1'b0);
        issue(1'b0, 15'h1235, 8'h00, 1'b0, 1'b0);
        issue(1'b1, 15'h0001, 8'hFF, 1'b1, 1'b0);   // R7 refused write
        issue(1'b0, 15'h0001, 8'h00, 1'b0, 1'b0);   // R7 contents unchanged
        issue(1'b0, 15'h7FFF, 8'h00, 1'b1, 1'b0);   // R7 refused read
        issue(1'b1, 15'h0002, 8'h77, 1'b0, 1'b1);   // R8 cut write
        issue(1'b1, 15'h0000, 8'h81, 1'b0, 1'b0);
        issue(1'b0, 15'h0000, 8'h00, 1'b0, 1'b0);

        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R2/R3 all completions seen", exp_q.size(), 0);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule